// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches three asynchronous external interrupt pins and turns each one into a request line for a downstream interrupt controller. Every pin first crosses into the clock domain through a synchronizer chain. A per-pin sense mode then decides what counts as a request.

Pins 0 and 1 may be level- or edge-sensitive. Pin 2 is edge-sensitive only. An edge is caught in a sticky flag that stays set until the controller acknowledges it or software writes a one to it. A low-level request is not stored and follows the pin. A per-pin enable bit gates each flag or level onto its request line. A masked pin still records its edge, so enabling it later raises the request at once.

Software reaches three 8-bit registers through a simple write port and a combinational read port: sense control, enable mask, and edge flags. Priority resolution and vectoring belong to the controller that consumes `req_o`.

Top module: `extirq_sense`

## Requirements
- R1: After synchronous reset, `req_o` is 0 and the control, mask and flag registers all read as 0x00.
- R2: A pin change is visible to the level logic after two rising clock edges. An edge flag sets on the third rising edge after the change reaches the pin, and not before.
- R3: Pin 0 uses control bits 1:0 and pin 1 uses bits 3:2. With code 00 the pin requests while its synchronized value is low and stops when it returns high. This request is not latched and leaves the flag bit at 0.
- R4: Code 01 sets the pin's edge flag on both a rising and a falling change.
- R5: Code 10 sets the flag only on a falling edge. Code 11 sets it only on a rising edge. Writing 0x0F selects rising edges for pins 0 and 1.
- R6: Pin 2 is edge-only, and its direction comes from control bit 4 (0 falling, 1 rising). Holding pin 2 at any level never raises a request once its flag is cleared.
- R7: Mask bit 6 enables pin 0, bit 7 enables pin 1 and bit 5 enables pin 2. A masked pin still sets its flag but drives no request. Setting the mask bit afterwards raises the request without a new edge.
- R8: An edge flag clears when the pin's `ack_i` bit is high at a clock edge, or when a one is written to its bit in the flag register. Writing a zero leaves it unchanged.
- R9: When a new qualifying edge and a clear (acknowledge or write-one) hit the same clock edge, the flag stays set.
- R10: Register select value 0 addresses control, 1 the mask and 2 the flags (same bit positions as the mask). Control bits 7:5 and mask bits 4:0 read as 0, and select value 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 3 | Asynchronous external interrupt pins |
| ack_i | input | 3 | Per-source acknowledge, clears the edge flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 8 | Read data (combinational) |
| req_o | output | 3 | Request lines to the interrupt controller |

## Verification
A wrong synchronizer depth shows up as a request that is one edge early or late against the fixed two- and three-edge latencies. The bench samples at exactly those points. A flag that sets on the wrong edge direction, or that loses a same-cycle new edge to a clear, shows on `req_o` and in the flag register read-back within three clocks of the pin change. A mask or flag bit at the wrong position shows at once on the combinational read port and on the request line of the affected pin.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NPIN  = 3;
    localparam int REG_W = 8;
    localparam int P2_DIR_BIT = 4;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } regsel_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_hist_t;

    // bit position of a pin in the mask and flag registers
    function automatic int en_bit(input int pin);
        case (pin)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction

    function automatic bit level_capable(input int pin);
        return pin < 2;
    endfunction

    function automatic logic [REG_W-1:0] mask_used();
        logic [REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < NPIN; p++) m[en_bit(p)] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] CTRL_USED = 8'h1F;

    function automatic sense_e pin_mode(input logic [REG_W-1:0] ctrl, input int pin);
        case (pin)
            0:       return sense_e'(ctrl[1:0]);
            1:       return sense_e'(ctrl[3:2]);
            default: return sense_e'({1'b1, ctrl[P2_DIR_BIT]});
        endcase
    endfunction

    function automatic logic edge_hit(input sense_e m, input pin_hist_t h);
        case (m)
            SENSE_ANY:  return h.cur ^ h.prev;
            SENSE_FALL: return h.prev & ~h.cur;
            SENSE_RISE: return ~h.prev & h.cur;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync
    import extirq_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      d,
    output pin_hist_t hist
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(LAST+1){RST_VAL}};
        else     chain <= {chain[LAST-1:0], d};
    end

    assign hist.cur  = chain[LAST-1];
    assign hist.prev = chain[LAST];
endmodule

// File: rtl/extirq_cell.sv
module extirq_cell
    import extirq_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_hist_t hist,
    input  sense_e    mode,
    input  logic      enable,
    input  logic      ack,
    input  logic      w1c,
    output logic      flag,
    output logic      req
);
    logic hit;
    logic level_sel;
    logic flag_q;

    assign hit = edge_hit(mode, hist);

    generate
        if (LEVEL_OK) begin : g_lvl
            assign level_sel = (mode == SENSE_LOW);
        end else begin : g_edge_only
            assign level_sel = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)              flag_q <= 1'b0;
        else if (hit)         flag_q <= 1'b1;
        else if (ack || w1c)  flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign req  = enable & (level_sel ? ~hist.cur : flag_q);
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  regsel_e          wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  regsel_e          rd_sel,
    input  logic [NPIN-1:0]  flags,
    output logic [REG_W-1:0] ctrl,
    output logic [NPIN-1:0]  enable,
    output logic [NPIN-1:0]  w1c,
    output logic [REG_W-1:0] rd_data
);
    localparam logic [REG_W-1:0] MASK_USED = mask_used();

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] flag_img;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= wr_data & CTRL_USED;
            if (wr_sel == SEL_MASK) mask_q <= wr_data & MASK_USED;
        end
    end

    genvar p;
    generate
        for (p = 0; p < NPIN; p++) begin : g_pin
            localparam int EB = en_bit(p);
            assign enable[p] = mask_q[EB];
            assign w1c[p]    = wr_en && (wr_sel == SEL_FLAG) && wr_data[EB];
        end
    endgenerate

    always_comb begin
        flag_img = '0;
        for (int q = 0; q < NPIN; q++) flag_img[en_bit(q)] = flags[q];
    end

    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_MASK: rd_data = mask_q;
            SEL_FLAG: rd_data = flag_img;
            default:  rd_data = '0;
        endcase
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/extirq_sense.sv
module extirq_sense
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  pin_i,
    input  logic [NPIN-1:0]  ack_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [1:0]       rd_sel_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [NPIN-1:0]  req_o
);
    logic [REG_W-1:0] ctrl_vec;
    logic [NPIN-1:0]  mask_vec;
    logic [NPIN-1:0]  flag_vec;
    logic [NPIN-1:0]  w1c_vec;

    extirq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_sel  (regsel_e'(wr_sel_i)),
        .wr_data (wr_data_i),
        .rd_sel  (regsel_e'(rd_sel_i)),
        .flags   (flag_vec),
        .ctrl    (ctrl_vec),
        .enable  (mask_vec),
        .w1c     (w1c_vec),
        .rd_data (rd_data_o)
    );

    genvar p;
    generate
        for (p = 0; p < NPIN; p++) begin : g_pin
            pin_hist_t hist;

            extirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .d    (pin_i[p]),
                .hist (hist)
            );

            extirq_cell #(.LEVEL_OK(level_capable(p))) u_cell (
                .clk    (clk),
                .rst    (rst),
                .hist   (hist),
                .mode   (pin_mode(ctrl_vec, p)),
                .enable (mask_vec[p]),
                .ack    (ack_i[p]),
                .w1c    (w1c_vec[p]),
                .flag   (flag_vec[p]),
                .req    (req_o[p])
            );
        end
    endgenerate
endmodule

// File: rtl/extirq_sense_chk.sv
module extirq_sense_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] pin_i,
    input logic [2:0] ack_i,
    input logic [2:0] clr_w,
    input logic [3:0] ctrl_lo,
    input logic [2:0] mask_vec,
    input logic [2:0] flag_vec,
    input logic [2:0] req_o
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (req_o == 3'b000 && flag_vec == 3'b000)) // R1
        else $error("AST_RESET_QUIET");

    AST_MASK_GATES_REQ: assert property (@(posedge clk) disable iff (rst) (req_o & ~mask_vec) == 3'b000) // R7
        else $error("AST_MASK_GATES_REQ");

    AST_PIN2_NO_LEVEL: assert property (@(posedge clk) disable iff (rst) req_o[2] |-> flag_vec[2]) // R6
        else $error("AST_PIN2_NO_LEVEL");

    AST_LEVEL_PIN0: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd3 && ctrl_lo[1:0] == 2'b00 && mask_vec[0]) |-> (req_o[0] == !$past(pin_i[0], 2))) // R3
        else $error("AST_LEVEL_PIN0");

    AST_LEVEL_PIN1: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd3 && ctrl_lo[3:2] == 2'b00 && mask_vec[1]) |-> (req_o[1] == !$past(pin_i[1], 2))) // R3
        else $error("AST_LEVEL_PIN1");

    genvar i;
    generate
        for (i = 0; i < 3; i++) begin : g_chk
            AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
                (age >= 3'd5 && $rose(flag_vec[i])) |-> ($past(pin_i[i], 3) != $past(pin_i[i], 4))) // R2
                else $error("AST_FLAG_NEEDS_EDGE");

            AST_CLEAR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
                (age >= 3'd2 && $fell(flag_vec[i])) |-> $past(ack_i[i] | clr_w[i])) // R8
                else $error("AST_CLEAR_NEEDS_CAUSE");
        end
    endgenerate
endmodule

bind extirq_sense extirq_sense_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (pin_i),
    .ack_i    (ack_i),
    .clr_w    (w1c_vec),
    .ctrl_lo  (ctrl_vec[3:0]),
    .mask_vec (mask_vec),
    .flag_vec (flag_vec),
    .req_o    (req_o)
);

// File: tb/extirq_sense_bench.sv
module extirq_sense_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pin_i = 3'b111;
    logic [2:0] ack_i = 3'b000;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = 2'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic [1:0] rd_sel_i = 2'd0;
    logic [7:0] rd_data_o;
    logic [2:0] req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    extirq_sense u_extirq_sense (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i),
        .ack_i     (ack_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .req_o     (req_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // advance n rising edges, return at the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        tick(1);
        wr_en_i = 1'b0; wr_data_i = 8'h00;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel_i = sel;
        #1;
        check(tag, rd_data_o, exp);
    endtask

    task automatic pulse_ack(input logic [2:0] a);
        ack_i = a;
        tick(1);
        ack_i = 3'b000;
    endtask

    task automatic t_reset();
        check("R1 req after reset", {5'd0, req_o}, 8'h00);
        rd_check("R1 ctrl after reset", 2'd0, 8'h00);
        rd_check("R1 mask after reset", 2'd1, 8'h00);
        rd_check("R1 flags after reset", 2'd2, 8'h00);
    endtask

    task automatic t_regs();
        wr(2'd0, 8'hFF);
        rd_check("R10 ctrl spare bits", 2'd0, 8'h1F);
        wr(2'd1, 8'hFF);
        rd_check("R10 mask spare bits", 2'd1, 8'hE0);
        rd_check("R10 select 3", 2'd3, 8'h00);
        check("R10 no req without edge", {5'd0, req_o}, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_level();
        wr(2'd1, 8'h40);
        pin_i[0] = 1'b0;
        tick(1);
        check("R2 level not yet after 1 edge", {7'd0, req_o[0]}, 8'h00);
        tick(1);
        check("R3 level request pin0", {7'd0, req_o[0]}, 8'h01);
        rd_check("R3 level not latched in flag", 2'd2, 8'h00);
        tick(3);
        check("R3 level held", {7'd0, req_o[0]}, 8'h01);
        pin_i[0] = 1'b1;
        tick(2);
        check("R3 level drops with pin", {7'd0, req_o[0]}, 8'h00);
    endtask

    task automatic t_rise();
        wr(2'd0, 8'h0F);
        pin_i[0] = 1'b0;
        tick(4);
        check("R5 rising ignores fall", {5'd0, req_o}, 8'h00);
        pin_i[0] = 1'b1;
        tick(2);
        rd_check("R2 flag not yet after 2 edges", 2'd2, 8'h00);
        tick(1);
        check("R5 rising sets req pin0", {5'd0, req_o}, 8'h01);
        rd_check("R7 flag bit6 for pin0", 2'd2, 8'h40);
        pulse_ack(3'b001);
        check("R8 ack clears pin0", {5'd0, req_o}, 8'h00);
        rd_check("R8 flag after ack", 2'd2, 8'h00);
    endtask

    task automatic t_fall();
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h80);
        pin_i[1] = 1'b0;
        tick(3);
        check("R5 falling sets req pin1", {5'd0, req_o}, 8'h02);
        wr(2'd2, 8'h00);
        check("R8 write zero keeps flag", {5'd0, req_o}, 8'h02);
        wr(2'd2, 8'h80);
        check("R8 write one clears flag", {5'd0, req_o}, 8'h00);
        pin_i[1] = 1'b1;
        tick(4);
        check("R5 falling ignores rise", {5'd0, req_o}, 8'h00);
    endtask

    task automatic t_any();
        wr(2'd0, 8'h04);
        pin_i[1] = 1'b0;
        tick(3);
        check("R4 any-change on fall", {5'd0, req_o}, 8'h02);
        wr(2'd2, 8'h80);
        pin_i[1] = 1'b1;
        tick(3);
        check("R4 any-change on rise", {5'd0, req_o}, 8'h02);
        wr(2'd2, 8'h80);
        check("R4 cleared", {5'd0, req_o}, 8'h00);
    endtask

    task automatic t_pin2();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h20);
        pin_i[2] = 1'b0;
        tick(3);
        check("R6 pin2 falling sets req", {5'd0, req_o}, 8'h04);
        wr(2'd2, 8'h20);
        tick(5);
        check("R6 pin2 low level no req", {5'd0, req_o}, 8'h00);
        wr(2'd0, 8'h10);
        pin_i[2] = 1'b1;
        tick(3);
        check("R6 pin2 rising sets req", {5'd0, req_o}, 8'h04);
        pulse_ack(3'b100);
        tick(4);
        check("R6 pin2 high level no req", {5'd0, req_o}, 8'h00);
    endtask

    task automatic t_mask();
        wr(2'd1, 8'h00);
        pin_i[2] = 1'b0;
        tick(4);
        pin_i[2] = 1'b1;
        tick(3);
        check("R7 masked pin no req", {5'd0, req_o}, 8'h00);
        rd_check("R7 masked flag recorded bit5", 2'd2, 8'h20);
        wr(2'd1, 8'h20);
        check("R7 unmask raises req", {5'd0, req_o}, 8'h04);
        pulse_ack(3'b100);
        check("R7 cleared", {5'd0, req_o}, 8'h00);
    endtask

    task automatic t_collide();
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h80);
        pin_i[1] = 1'b0;
        tick(3);
        check("R9 setup flag", {5'd0, req_o}, 8'h02);
        pin_i[1] = 1'b1;
        tick(2);
        pulse_ack(3'b010);
        check("R9 edge wins over ack", {5'd0, req_o}, 8'h02);
        pulse_ack(3'b010);
        check("R9 later ack clears", {5'd0, req_o}, 8'h00);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_regs();
        t_level();
        t_rise();
        t_fall();
        t_any();
        t_pin2();
        t_mask();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule